// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor (modulo 2N)

This block adds or subtracts two multi-precision residues modulo 2N, where N is an odd modulus. It walks through the operands one w-bit word at a time. Every operand sits in a shared, word-addressed scratch memory as E words. Register r, word j is at address r*E + j, and word 0 is the least significant word. The memory is outside the block. It offers two combinational read ports and one write port that commits on the clock edge. The caller loads the operands and the doubled modulus into registers of its choice. It names them on the select inputs and pulses `start`.

One word adder does both operations. In subtraction it inverts the second operand and forces the first carry in to 1. An addition takes three passes over the words: form x+y, always form the candidate x+y−2N in a temporary register, then copy the candidate back when its sign is non-negative. A subtraction takes two passes: form x−y, then add 2N back when the first pass borrowed. Each pass uses E word cycles plus one cycle in which the carry is settled. The pass count does not depend on the data. Many copies of the block can therefore run the same command stream in lockstep.

Top module: `wmod2n_addsub`

## Requirements
- R1: With x, y < 2N, an addition leaves (x + y) mod 2N in the destination register. This also holds when x + y overflows E*W bits.
- R2: With x, y < 2N, a subtraction leaves (x − y) mod 2N, in [0, 2N), in the destination register.
- R3: An addition keeps `busy` high for exactly 3(E+1) cycles, whether or not the correction is applied. `done` is high in the last of these cycles. The first busy cycle is the one after the clock edge that samples `start`.
- R4: A subtraction keeps `busy` high for exactly 2(E+1) cycles, whether or not the correction is applied. `done` is high in the last of these cycles.
- R5: `done` is a one-cycle pulse. `busy` is low in the cycle after `done`.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its operation type, its result and its latency.
- R7: The source registers and the 2N register are never written. A subtraction never writes the temporary register.
- R8: Register r, word j is at address r*E + j, with word 0 least significant. Every write address is below NREG*E.
- R9: `wr_en` is high only while `busy` is high.
- R10: After reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| sub | input | 1 | 0 = addition, 1 = subtraction, sampled with start |
| sel_x | input | RW | Register index of the first operand |
| sel_y | input | RW | Register index of the second operand |
| sel_z | input | RW | Register index of the result |
| sel_t | input | RW | Register index of the temporary candidate |
| sel_m2 | input | RW | Register index holding 2N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | High in the final cycle of an operation |
| rd_a_addr | output | AW | Word address, read port A |
| rd_a_data | input | W | Word read from port A |
| rd_b_addr | output | AW | Word address, read port B |
| rd_b_data | input | W | Word read from port B |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | AW | Word write address |
| wr_data | output | W | Word write data |

## Verification
The bench uses 4-bit words and two words per register. For small moduli it tries every pair x, y < 2N. Exhaustive pairs separate the wrap case from the no-wrap case, and they hit the exact boundary x + y = 2N and the case x = y. With 2N close to 2^8 a strided sweep and the extreme corners make the first addition pass carry out of the top word. That exposes any sign decision that ignores the carry. Every operation is also timed against its fixed latency. Runs that inject a second `start` mid-operation show whether the operation type or the timing can be disturbed.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Role of a register within one pass
  typedef enum logic [2:0] {
    ROLE_X,
    ROLE_Y,
    ROLE_Z,
    ROLE_T,
    ROLE_M2
  } role_e;

  typedef struct packed {
    role_e src_a;
    role_e src_b;
    role_e dst;
    logic  inv_b;   // complement second operand
    logic  zero_b;  // second operand forced to zero (copy pass)
    logic  cin0;    // carry into word 0
  } pass_cfg_t;

  // Pass schedule for both operations
  function automatic pass_cfg_t pass_cfg(input logic is_sub, input logic [1:0] pass);
    pass_cfg_t c;
    if (!is_sub) begin
      case (pass)
        2'd0:    c = '{src_a: ROLE_X, src_b: ROLE_Y,  dst: ROLE_Z, inv_b: 1'b0, zero_b: 1'b0, cin0: 1'b0};
        2'd1:    c = '{src_a: ROLE_Z, src_b: ROLE_M2, dst: ROLE_T, inv_b: 1'b1, zero_b: 1'b0, cin0: 1'b1};
        default: c = '{src_a: ROLE_T, src_b: ROLE_M2, dst: ROLE_Z, inv_b: 1'b0, zero_b: 1'b1, cin0: 1'b0};
      endcase
    end else begin
      case (pass)
        2'd0:    c = '{src_a: ROLE_X, src_b: ROLE_Y,  dst: ROLE_Z, inv_b: 1'b1, zero_b: 1'b0, cin0: 1'b1};
        default: c = '{src_a: ROLE_Z, src_b: ROLE_M2, dst: ROLE_Z, inv_b: 1'b0, zero_b: 1'b0, cin0: 1'b0};
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/wm_seq.sv
module wm_seq #(
  parameter int E = 7,
  localparam int WIDX_W = $clog2(E + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub_in,
  output logic              busy,
  output logic              op_sub,
  output logic [1:0]        pass,
  output logic [WIDX_W-1:0] word,
  output logic              word_act,
  output logic              pass_end,
  output logic              last_pass,
  output logic              done
);

  logic              busy_q, sub_q;
  logic [1:0]        pass_q;
  logic [WIDX_W-1:0] word_q;

  assign busy      = busy_q;
  assign op_sub    = sub_q;
  assign pass      = pass_q;
  assign word      = word_q;
  assign last_pass = sub_q ? (pass_q == 2'd1) : (pass_q == 2'd2);
  assign pass_end  = busy_q && (word_q == WIDX_W'(E));
  assign word_act  = busy_q && (word_q != WIDX_W'(E));
  assign done      = pass_end && last_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sub_q  <= 1'b0;
      pass_q <= 2'd0;
      word_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sub_q  <= sub_in;
        pass_q <= 2'd0;
        word_q <= '0;
      end
    end else if (pass_end) begin
      word_q <= '0;
      if (last_pass) busy_q <= 1'b0;
      else           pass_q <= pass_q + 2'd1;
    end else begin
      word_q <= word_q + WIDX_W'(1);
    end
  end

endmodule

// File: rtl/wm_word_adder.sv
module wm_word_adder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         zero_b,
  input  logic         cin0,
  input  logic         first,
  input  logic         step,
  output logic [W-1:0] sum,
  output logic         carry_q
);

  function automatic logic [W:0] add_word(input logic [W-1:0] p, input logic [W-1:0] q,
                                          input logic cin);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, cin};
  endfunction

  logic [W-1:0] b_eff;
  logic         cin;
  logic         cout;

  always_comb begin
    if (zero_b)     b_eff = '0;
    else if (inv_b) b_eff = ~b;
    else            b_eff = b;
    cin = first ? cin0 : carry_q;
    {cout, sum} = add_word(a, b_eff, cin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= 1'b0;
    else if (step) carry_q <= cout;
  end

endmodule

// File: rtl/wm_addr_gen.sv
module wm_addr_gen
  import wm_pkg::*;
#(
  parameter int E    = 7,
  parameter int NREG = 32,
  localparam int RW     = $clog2(NREG),
  localparam int AW     = $clog2(NREG * E),
  localparam int WIDX_W = $clog2(E + 1)
) (
  input  role_e             role,
  input  logic [RW-1:0]     sel_x,
  input  logic [RW-1:0]     sel_y,
  input  logic [RW-1:0]     sel_z,
  input  logic [RW-1:0]     sel_t,
  input  logic [RW-1:0]     sel_m2,
  input  logic [WIDX_W-1:0] word,
  output logic [AW-1:0]     addr
);

  logic [RW-1:0] idx;

  always_comb begin
    case (role)
      ROLE_X:  idx = sel_x;
      ROLE_Y:  idx = sel_y;
      ROLE_Z:  idx = sel_z;
      ROLE_T:  idx = sel_t;
      default: idx = sel_m2;
    endcase
    addr = AW'(int'(idx) * E + int'(word));
  end

endmodule

// File: rtl/wmod2n_addsub.sv
module wmod2n_addsub
  import wm_pkg::*;
#(
  parameter int W    = 32,
  parameter int E    = 7,
  parameter int NREG = 32,
  localparam int RW     = $clog2(NREG),
  localparam int AW     = $clog2(NREG * E),
  localparam int WIDX_W = $clog2(E + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sub,
  input  logic [RW-1:0] sel_x,
  input  logic [RW-1:0] sel_y,
  input  logic [RW-1:0] sel_z,
  input  logic [RW-1:0] sel_t,
  input  logic [RW-1:0] sel_m2,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] rd_a_addr,
  input  logic [W-1:0]  rd_a_data,
  output logic [AW-1:0] rd_b_addr,
  input  logic [W-1:0]  rd_b_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data
);

  logic              op_sub, word_act, pass_end, last_pass;
  logic [1:0]        pass;
  logic [WIDX_W-1:0] word;
  logic [W-1:0]      sum;
  logic              carry_q;
  logic              flag0_q;   // carry out of the first pass
  logic              keep_q;    // addition: candidate is non-negative
  logic              wr_gate;
  logic              corr_en;   // correction write enabled in the last pass
  pass_cfg_t         cfg;

  wm_seq #(.E(E)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sub_in   (sub),
    .busy     (busy),
    .op_sub   (op_sub),
    .pass     (pass),
    .word     (word),
    .word_act (word_act),
    .pass_end (pass_end),
    .last_pass(last_pass),
    .done     (done)
  );

  assign cfg = pass_cfg(op_sub, pass);

  // Three address ports share one generator structure
  role_e         roles [3];
  logic [AW-1:0] addrs [3];

  assign roles[0] = cfg.src_a;
  assign roles[1] = cfg.src_b;
  assign roles[2] = cfg.dst;

  for (genvar g = 0; g < 3; g++) begin : g_addr
    wm_addr_gen #(.E(E), .NREG(NREG)) u_ag (
      .role  (roles[g]),
      .sel_x (sel_x),
      .sel_y (sel_y),
      .sel_z (sel_z),
      .sel_t (sel_t),
      .sel_m2(sel_m2),
      .word  (word),
      .addr  (addrs[g])
    );
  end

  assign rd_a_addr = addrs[0];
  assign rd_b_addr = addrs[1];
  assign wr_addr   = addrs[2];

  wm_word_adder #(.W(W)) u_add (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (rd_a_data),
    .b      (rd_b_data),
    .inv_b  (cfg.inv_b),
    .zero_b (cfg.zero_b),
    .cin0   (cfg.cin0),
    .first  (word == '0),
    .step   (word_act),
    .sum    (sum),
    .carry_q(carry_q)
  );

  // Sign bookkeeping at pass boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag0_q <= 1'b0;
      keep_q  <= 1'b0;
    end else if (pass_end) begin
      if (pass == 2'd0) flag0_q <= carry_q;
      if (pass == 2'd1 && !op_sub) keep_q <= flag0_q | carry_q;
    end
  end

  always_comb begin
    corr_en = op_sub ? !flag0_q : keep_q;
    if (last_pass) wr_gate = corr_en;
    else           wr_gate = 1'b1;
  end

  assign wr_en   = word_act && wr_gate;
  assign wr_data = sum;

endmodule

// File: rtl/wmod2n_addsub_chk.sv
module wmod2n_addsub_chk #(
  parameter int E    = 7,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG * E)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sub,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);

  int   cnt_q;
  logic op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 0;
      op_q  <= 1'b0;
    end else if (!busy && start) begin
      cnt_q <= 1;
      op_q  <= sub;
    end else if (busy) begin
      cnt_q <= cnt_q + 1;
    end
  end

  assert_add_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q) |-> (cnt_q == 3 * (E + 1)));

  assert_sub_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> (cnt_q == 2 * (E + 1)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op_q)));

  assert_wr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NREG * E));

  assert_wr_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

endmodule

bind wmod2n_addsub wmod2n_addsub_chk #(.E(E), .NREG(NREG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .sub    (sub),
  .busy   (busy),
  .done   (done),
  .wr_en  (wr_en),
  .wr_addr(wr_addr)
);

// File: tb/wmod2n_addsub_tb.sv
module wmod2n_addsub_tb;

  localparam int W    = 4;
  localparam int E    = 2;
  localparam int NREG = 8;
  localparam int NB   = W * E;
  localparam int RW   = $clog2(NREG);
  localparam int AW   = $clog2(NREG * E);
  localparam int LAT_ADD = 3 * (E + 1);
  localparam int LAT_SUB = 2 * (E + 1);
  localparam int RX = 0, RY = 1, RZ = 2, RT = 3, RM = 4;
  localparam logic [NB-1:0] SENT = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sub_i = 1'b0;
  logic          busy, done, wr_en;
  logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [W-1:0]  rd_a_data, rd_b_data, wr_data;

  logic          ld = 1'b0;
  int            ld_idx = 0;
  logic [NB-1:0] ld_val = '0;
  logic [W-1:0]  mem [NREG*E];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wmod2n_addsub #(.W(W), .E(E), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub_i),
    .sel_x(RW'(RX)), .sel_y(RW'(RY)), .sel_z(RW'(RZ)), .sel_t(RW'(RT)), .sel_m2(RW'(RM)),
    .busy(busy), .done(done),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Scratch memory: combinational reads, clocked writes (R8 layout)
  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];

  always @(posedge clk) begin
    if (ld) begin
      for (int j = 0; j < E; j++) mem[ld_idx*E + j] <= ld_val[j*W +: W];
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  function automatic logic [NB-1:0] rd_reg(input int r);
    logic [NB-1:0] v;
    for (int j = 0; j < E; j++) v[j*W +: W] = mem[r*E + j];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int r, input logic [NB-1:0] v);
    @(negedge clk);
    ld = 1'b1; ld_idx = r; ld_val = v;
    @(negedge clk);
    ld = 1'b0;
  endtask

  // poke: issue a second start of the other kind in busy cycle 3
  task automatic run_op(input int x, input int y, input bit s, input int n2, input bit poke);
    int cyc, exp;
    load(RX, NB'(x));
    load(RY, NB'(y));
    load(RT, SENT);
    start = 1'b1; sub_i = s;
    @(negedge clk);
    start = 1'b0; sub_i = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      if (poke && cyc == 3) begin start = 1'b1; sub_i = !s; end
      else begin start = 1'b0; sub_i = 1'b0; end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; sub_i = 1'b0;
    if (poke) check(cyc == (s ? LAT_SUB : LAT_ADD), "R6 latency", cyc, s ? LAT_SUB : LAT_ADD);
    else if (s) check(cyc == LAT_SUB, "R4 latency", cyc, LAT_SUB);
    else        check(cyc == LAT_ADD, "R3 latency", cyc, LAT_ADD);
    @(negedge clk);
    check(!done && !busy, "R5 done pulse / busy drop", {30'd0, done, busy}, 0);
    if (s) exp = (x >= y) ? x - y : x - y + n2;
    else   exp = (x + y >= n2) ? x + y - n2 : x + y;
    check(int'(rd_reg(RZ)) == exp, s ? (poke ? "R6 R2 R8 result" : "R2 R8 result")
                                     : (poke ? "R6 R1 R8 result" : "R1 R8 result"),
          int'(rd_reg(RZ)), exp);
    check(int'(rd_reg(RX)) == x && int'(rd_reg(RY)) == y && int'(rd_reg(RM)) == n2,
          "R7 sources kept", int'(rd_reg(RX)), x);
    if (s) check(rd_reg(RT) == SENT, "R7 temp untouched by subtract", int'(rd_reg(RT)), int'(SENT));
  endtask

  task automatic sweep(input int n, input int sx, input int sy);
    int n2;
    n2 = 2 * n;
    load(RM, NB'(n2));
    for (int x = 0; x < n2; x += sx) begin
      for (int y = 0; y < n2; y += sy) begin
        run_op(x, y, 1'b0, n2, 1'b0);
        run_op(x, y, 1'b1, n2, 1'b0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NREG*E; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_en, "R10 reset state", {29'd0, busy, done, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wr_en, "R10 R9 idle after reset", {29'd0, busy, done, wr_en}, 0);

    sweep(5, 1, 1);
    sweep(23, 1, 1);
    sweep(127, 9, 13);
    // corners with carry out of the top word (2N = 254)
    run_op(253, 253, 1'b0, 254, 1'b0);
    run_op(253, 253, 1'b1, 254, 1'b0);
    run_op(0, 253, 1'b1, 254, 1'b0);
    run_op(253, 0, 1'b1, 254, 1'b0);
    run_op(0, 0, 1'b0, 254, 1'b0);
    run_op(127, 127, 1'b0, 254, 1'b0);
    // R6: stray start during busy
    run_op(200, 100, 1'b0, 254, 1'b1);
    run_op(10, 200, 1'b1, 254, 1'b1);
    run_op(100, 154, 1'b0, 254, 1'b1);
    run_op(250, 3, 1'b1, 254, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule